// File: doc/BRIEF.md
# Indirect-Access Control/Status Register Bank

This block is the host-facing register bank of a network controller. The host reaches four 16-bit registers through two ports. It first loads a 2-bit register index into the select port. It then reads or writes the chosen register through the data port. The index stays in place until the host loads a new one, so a run of data-port accesses all reach the same register.

Register 0 is the control/status word. Its low nibble holds commands that the host sets by writing ones: init, start, stop and transmit demand. Above that sit the transmitter-on and receiver-on flags, the interrupt enable and the interrupt-pending flag. Bits 8 to 14 latch single-cycle event pulses from the transmit, receive and memory logic, and bit 15 summarises the error events. An interrupt request output follows from the pending flag and the enable.

Registers 1 to 3 hold the init-block address and three configuration bits. The host can reach them only while the controller is stopped. The block drives the run state, the assembled 24-bit init address and the configuration bits to the rest of the controller.

Top module: `nic_csr_bank`

## Requirements
- R1: After reset the index is 0, register 0 reads 0x0004 (only the stopped bit 2 set), `stopped` is 1, `irq` is 0, and registers 1 to 3, `init_addr` and `cfg_bits` are zero.
- R2: A select-port write loads a 2-bit index on the clock edge. The index picks the register that the data port reaches and holds through any number of data accesses until the next select write.
- R3: In register 0, writing a one to bit 0 (init) or bit 1 (start) sets it and clears stop (bit 2). Start also sets transmitter-on (bit 4) and receiver-on (bit 5). Writing one to bit 3 sets transmit demand. Writing zero to bits 0 to 3 has no effect.
- R4: Writing one to bit 2 (stop) sets stopped and clears bits 0, 1, 3, 4 and 5. Stop wins over init or start written in the same word.
- R5: Event input `hw_evt[i]` latches bit 8+i of register 0: init done, transmit, receive, memory error, missed frame, collision-test error and babble for i = 0 to 6. Writing one to a bit in 14:8 clears it, and writing zero leaves it set.
- R6: Bit 15 reads as the OR of bits 14:11. Bit 7 reads as the OR of bits 15:8.
- R7: Bit 6 is a read/write interrupt enable. `irq` is high exactly when bits 7 and 6 are both set.
- R8: Writes to bits 4, 5, 7 and 15 of register 0 have no effect.
- R9: While stopped, register 1 stores the written word with bit 0 forced to 0. Register 2 stores bits 7:0 and reads zero above them. Register 3 stores bits 2:0 and reads zero above them. `init_addr` is {reg2[7:0], reg1} and `cfg_bits` is reg3[2:0].
- R10: While not stopped, data writes to registers 1 to 3 are ignored and reads of them return 0.
- R11: When an event pulse and a host clear hit the same bit in the same cycle, the bit ends up set.
- R12: A transmit event clears transmit demand (bit 3), and an init-done event clears init (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Load the register index |
| sel_idx | input | 2 | Register index to load |
| data_wr | input | 1 | Write the selected register |
| wdata | input | 16 | Data-port write word |
| rdata | output | 16 | Data-port read word for the selected register |
| hw_evt | input | 7 | Single-cycle event pulses, bit i latches register 0 bit 8+i |
| irq | output | 1 | Interrupt request |
| stopped | output | 1 | Controller is stopped |
| tx_on | output | 1 | Transmitter enabled |
| rx_on | output | 1 | Receiver enabled |
| init_addr | output | 24 | Init-block address |
| cfg_bits | output | 3 | Configuration bits from register 3 |

## Verification
The bench writes stop together with init and start. A design that gave start priority would be left running with transmitter-on set. It fires an event in the same cycle as a host clear of that bit, and a design where the clear wins would lose the event. It writes all ones to the read-only bits and tries to reach registers 1 to 3 while running, which catches a design that stores those writes or leaks the stored values. It also reads the same register several times after one select write, which catches an index that drifts or resets between accesses.

// File: rtl/nic_csr_pkg.sv
// Shared constants for the control/status register bank.
// Assumes a 16-bit register word and seven event sources.
package nic_csr_pkg;
    localparam int CSR_W   = 16;
    localparam int NUM_CSR = 4;
    localparam int IDX_W   = $clog2(NUM_CSR);
    localparam int EVT_N   = 7;
    localparam int HI_W    = 8;
    localparam int CFG_W   = 3;

    // Bit positions in register 0
    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TDMD = 3;
    localparam int B_TXON = 4;
    localparam int B_RXON = 5;
    localparam int B_IE   = 6;
    localparam int B_PEND = 7;
    localparam int B_EVT0 = 8;
    localparam int B_ESUM = 15;

    // Event indices inside the event field
    localparam int E_IDONE = 0;
    localparam int E_TX    = 1;
    localparam int E_ERR0  = 3;

    typedef enum logic [IDX_W-1:0] {
        CSR_CTRL = 2'd0,
        CSR_ADLO = 2'd1,
        CSR_ADHI = 2'd2,
        CSR_CFG  = 2'd3
    } csr_idx_e;
endpackage

// File: rtl/nic_csr_sel.sv
// Index register for the select port.
// Loads on sel_wr and otherwise holds its value.
module nic_csr_sel #(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_wr,
    input  logic [IW-1:0] sel_in,
    output logic [IW-1:0] sel_q
);
    // Hold the index until the host loads a new one
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= sel_in;
    end
endmodule

// File: rtl/nic_csr_ctrl.sv
// Register 0: commands, run flags, interrupt enable and latched events.
// Assumes events are single-cycle pulses.
// An event beats a host clear of the same bit, and stop beats start and init.
module nic_csr_ctrl
    import nic_csr_pkg::*;
#(
    parameter int W  = CSR_W,
    parameter int EN = EVT_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    input  logic [EN-1:0] hw_evt,
    output logic [W-1:0]  word,
    output logic          stopped,
    output logic          tx_on,
    output logic          rx_on,
    output logic          irq
);
    localparam int EHI = B_EVT0 + EN - 1;

    logic          init_q, strt_q, stop_q, tdmd_q, txon_q, rxon_q, ie_q;
    logic          init_n, strt_n, stop_n, tdmd_n, txon_n, rxon_n, ie_n;
    logic [EN-1:0] evt_q, evt_n;
    logic          esum, pend;

    // Next-state logic for the commands, flags and event latches
    always_comb begin
        init_n = init_q;
        strt_n = strt_q;
        stop_n = stop_q;
        tdmd_n = tdmd_q;
        txon_n = txon_q;
        rxon_n = rxon_q;
        ie_n   = ie_q;
        evt_n  = evt_q;
        if (wr_en) begin
            ie_n  = wdata[B_IE];
            evt_n = evt_q & ~wdata[EHI:B_EVT0];
            if (wdata[B_STOP]) begin
                stop_n = 1'b1;
                init_n = 1'b0;
                strt_n = 1'b0;
                tdmd_n = 1'b0;
                txon_n = 1'b0;
                rxon_n = 1'b0;
            end else begin
                if (wdata[B_INIT]) begin
                    init_n = 1'b1;
                    stop_n = 1'b0;
                end
                if (wdata[B_STRT]) begin
                    strt_n = 1'b1;
                    stop_n = 1'b0;
                    txon_n = 1'b1;
                    rxon_n = 1'b1;
                end
                if (wdata[B_TDMD]) tdmd_n = 1'b1;
            end
        end
        if (hw_evt[E_IDONE]) init_n = 1'b0;
        if (hw_evt[E_TX])    tdmd_n = 1'b0;
        evt_n = evt_n | hw_evt;
    end

    // State update with reset to the stopped state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b0;
            strt_q <= 1'b0;
            stop_q <= 1'b1;
            tdmd_q <= 1'b0;
            txon_q <= 1'b0;
            rxon_q <= 1'b0;
            ie_q   <= 1'b0;
            evt_q  <= '0;
        end else begin
            init_q <= init_n;
            strt_q <= strt_n;
            stop_q <= stop_n;
            tdmd_q <= tdmd_n;
            txon_q <= txon_n;
            rxon_q <= rxon_n;
            ie_q   <= ie_n;
            evt_q  <= evt_n;
        end
    end

    // Summary flags derived from the event latches
    always_comb begin
        esum = |evt_q[EN-1:E_ERR0];
        pend = |evt_q;
    end

    // Assemble the readable word and the outputs
    always_comb begin
        word         = '0;
        word[B_INIT] = init_q;
        word[B_STRT] = strt_q;
        word[B_STOP] = stop_q;
        word[B_TDMD] = tdmd_q;
        word[B_TXON] = txon_q;
        word[B_RXON] = rxon_q;
        word[B_IE]   = ie_q;
        word[B_PEND] = pend;
        word[EHI:B_EVT0] = evt_q;
        word[B_ESUM] = esum;
        stopped = stop_q;
        tx_on   = txon_q;
        rx_on   = rxon_q;
        irq     = pend & ie_q;
    end
endmodule

// File: rtl/nic_csr_cfg.sv
// Registers 1 to 3: init-block address (low and high) and configuration bits.
// Assumes the caller gates the write strobes with the stopped state.
module nic_csr_cfg #(
    parameter int W  = 16,
    parameter int HW = 8,
    parameter int CW = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic         wr_cfg,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] lo_q,
    output logic [HW-1:0] hi_q,
    output logic [CW-1:0] cfg_q
);
    // Low address word, bit 0 always zero
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (wr_lo) lo_q <= {wdata[W-1:1], 1'b0};
    end

    // High address byte
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (wr_hi) hi_q <= wdata[HW-1:0];
    end

    // Configuration bits
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= wdata[CW-1:0];
    end
endmodule

// File: rtl/nic_csr_bank.sv
// Top of the control/status register bank: index register, register 0,
// address and config registers, and the data-port read mux.
// Registers 1 to 3 are reachable only while stopped.
module nic_csr_bank
    import nic_csr_pkg::*;
#(
    parameter int DW  = CSR_W,
    parameter int IW  = IDX_W,
    parameter int EN  = EVT_N,
    parameter int AHW = HI_W,
    parameter int CW  = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [IW-1:0]     sel_idx,
    input  logic              data_wr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [EN-1:0]     hw_evt,
    output logic              irq,
    output logic              stopped,
    output logic              tx_on,
    output logic              rx_on,
    output logic [DW+AHW-1:0] init_addr,
    output logic [CW-1:0]     cfg_bits
);
    logic [IW-1:0]  sel_q;
    logic [DW-1:0]  csr0;
    logic [DW-1:0]  lo_q;
    logic [AHW-1:0] hi_q;
    logic [CW-1:0]  cfg_q;
    logic           wr0, wr_lo, wr_hi, wr_cfg;

    nic_csr_sel #(.IW(IW)) u_sel (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_in(sel_idx), .sel_q(sel_q)
    );

    // Per-register write strobes; registers 1 to 3 only while stopped
    always_comb begin
        wr0    = data_wr && (sel_q == CSR_CTRL);
        wr_lo  = data_wr && stopped && (sel_q == CSR_ADLO);
        wr_hi  = data_wr && stopped && (sel_q == CSR_ADHI);
        wr_cfg = data_wr && stopped && (sel_q == CSR_CFG);
    end

    nic_csr_ctrl #(.W(DW), .EN(EN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr0), .wdata(wdata), .hw_evt(hw_evt),
        .word(csr0), .stopped(stopped), .tx_on(tx_on), .rx_on(rx_on), .irq(irq)
    );

    nic_csr_cfg #(.W(DW), .HW(AHW), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_cfg(wr_cfg),
        .wdata(wdata), .lo_q(lo_q), .hi_q(hi_q), .cfg_q(cfg_q)
    );

    // Data-port read mux; registers 1 to 3 read zero while running
    always_comb begin
        rdata = '0;
        case (sel_q)
            CSR_CTRL: rdata = csr0;
            CSR_ADLO: if (stopped) rdata = lo_q;
            CSR_ADHI: if (stopped) rdata[AHW-1:0] = hi_q;
            default:  if (stopped) rdata[CW-1:0] = cfg_q;
        endcase
    end

    // Outputs to the rest of the controller
    always_comb begin
        init_addr = {hi_q, lo_q};
        cfg_bits  = cfg_q;
    end
endmodule

// File: rtl/nic_csr_bank_chk.sv
// Assertion checker for nic_csr_bank, attached by bind.
module nic_csr_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel_wr,
    input logic [1:0]  sel_q,
    input logic        data_wr,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic [6:0]  hw_evt,
    input logic [15:0] csr0,
    input logic        irq,
    input logic        stopped,
    input logic        tx_on,
    input logic        rx_on
);
    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(sel_q));

    // R4
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && sel_q == 2'd0 && wdata[2]) |=> (stopped && !tx_on && !rx_on));

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr0[6] && csr0[7]));

    // R10
    running_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && sel_q != 2'd0) |-> (rdata == 16'h0000));

    // R11
    event_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt[6] |=> csr0[14]);

    // R6
    err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt[3] |=> (csr0[15] && csr0[7]));
endmodule

bind nic_csr_bank nic_csr_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_q(sel_q), .data_wr(data_wr),
    .wdata(wdata), .rdata(rdata), .hw_evt(hw_evt), .csr0(csr0), .irq(irq),
    .stopped(stopped), .tx_on(tx_on), .rx_on(rx_on)
);

// File: tb/nic_csr_bank_bench.sv
// Scoreboard bench for nic_csr_bank: tasks drive the ports and queue
// expected values; a monitor pops and compares them between clock edges.
module nic_csr_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [1:0]  sel_idx = '0;
    logic        data_wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [6:0]  hw_evt = '0;
    logic        irq, stopped, tx_on, rx_on;
    logic [23:0] init_addr;
    logic [2:0]  cfg_bits;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int          sig;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    nic_csr_bank u_nic_csr_bank (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_idx(sel_idx),
        .data_wr(data_wr), .wdata(wdata), .rdata(rdata), .hw_evt(hw_evt),
        .irq(irq), .stopped(stopped), .tx_on(tx_on), .rx_on(rx_on),
        .init_addr(init_addr), .cfg_bits(cfg_bits)
    );

    // Monitor: compare queued expectations away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.sig)
                    0: act = {16'h0, rdata};
                    1: act = {31'h0, irq};
                    2: act = {31'h0, stopped};
                    3: act = {8'h0, init_addr};
                    default: act = {29'h0, cfg_bits};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: sig %0d actual %h expected %h", it.tag, it.sig, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input int sig, input logic [31:0] exp, input string tag);
        @(negedge clk);
        sb.push_back('{sig, exp, tag});
        wait (sb.size() == 0);
    endtask

    task automatic do_sel(input logic [1:0] i);
        @(negedge clk); sel_wr = 1'b1; sel_idx = i;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic do_wr(input logic [15:0] d);
        @(negedge clk); data_wr = 1'b1; wdata = d;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic do_evt(input logic [6:0] m);
        @(negedge clk); hw_evt = m;
        @(negedge clk); hw_evt = '0;
    endtask

    task automatic do_wr_evt(input logic [15:0] d, input logic [6:0] m);
        @(negedge clk); data_wr = 1'b1; wdata = d; hw_evt = m;
        @(negedge clk); data_wr = 1'b0; hw_evt = '0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_val(0, 32'h0004, "R1 reg0");
        expect_val(2, 32'h1, "R1 stopped");
        expect_val(1, 32'h0, "R1 irq");
        expect_val(3, 32'h0, "R1 init_addr");
        // R9 config registers while stopped
        do_sel(2'd1); do_wr(16'h1235);
        expect_val(0, 32'h1234, "R9 reg1 bit0 forced");
        do_sel(2'd2); do_wr(16'hABCD);
        expect_val(0, 32'h00CD, "R9 reg2");
        do_sel(2'd3); do_wr(16'hFFFF);
        expect_val(0, 32'h0007, "R9 reg3");
        expect_val(3, 32'hCD1234, "R9 init_addr");
        expect_val(4, 32'h7, "R9 cfg_bits");
        // R2 selection persists
        do_sel(2'd1); do_wr(16'h0002);
        expect_val(0, 32'h0002, "R2 first read");
        expect_val(0, 32'h0002, "R2 second read");
        do_sel(2'd0);
        expect_val(0, 32'h0004, "R2 back to reg0");
        // R3 zero writes ignored, start sets run flags
        do_wr(16'h0000);
        expect_val(0, 32'h0004, "R3 zero write");
        do_wr(16'h0002);
        expect_val(0, 32'h0032, "R3 start");
        expect_val(2, 32'h0, "R3 running");
        // R10 running hides and protects regs 1-3
        do_sel(2'd1);
        expect_val(0, 32'h0000, "R10 read while running");
        do_wr(16'hFFFF);
        do_sel(2'd0); do_wr(16'h0004);
        expect_val(0, 32'h0004, "R4 stop");
        do_sel(2'd1);
        expect_val(0, 32'h0002, "R10 write ignored");
        do_sel(2'd0);
        // R8 read-only bits
        do_wr(16'h80B0);
        expect_val(0, 32'h0004, "R8 read-only bits");
        // R4 stop wins over init/start
        do_wr(16'h0007);
        expect_val(0, 32'h0004, "R4 stop priority");
        do_wr(16'h0003);
        expect_val(0, 32'h0033, "R3 init+start");
        do_wr(16'h0006);
        expect_val(0, 32'h0004, "R4 stop after run");
        // R5, R7 events and interrupt
        do_wr(16'h0002);
        do_evt(7'h02);
        expect_val(0, 32'h02B2, "R5 tx event latched");
        expect_val(1, 32'h0, "R7 irq disabled");
        do_wr(16'h0040);
        expect_val(0, 32'h02F2, "R7 enable set");
        expect_val(1, 32'h1, "R7 irq asserted");
        do_wr(16'h0040);
        expect_val(0, 32'h02F2, "R5 zero keeps event");
        do_wr(16'h0240);
        expect_val(0, 32'h0072, "R5 clear event");
        expect_val(1, 32'h0, "R7 irq cleared");
        // R6 error summary
        do_evt(7'h08);
        expect_val(0, 32'h88F2, "R6 memory error summary");
        do_wr(16'h0840);
        expect_val(0, 32'h0072, "R6 cleared");
        do_evt(7'h40);
        expect_val(0, 32'hC0F2, "R6 babble summary");
        do_wr(16'h4040);
        expect_val(0, 32'h0072, "R6 babble cleared");
        // R11 event beats clear
        do_wr_evt(16'h0440, 7'h04);
        expect_val(0, 32'h04F2, "R11 event wins");
        do_wr(16'h0440);
        expect_val(0, 32'h0072, "R11 later clear");
        // R12 transmit demand and init self-clear
        do_wr(16'h0048);
        expect_val(0, 32'h007A, "R12 tdmd set");
        do_evt(7'h02);
        expect_val(0, 32'h02F2, "R12 tdmd cleared by tx");
        do_wr(16'h0240);
        do_wr(16'h0044);
        expect_val(0, 32'h0044, "R4 stop keeps enable");
        do_wr(16'h0041);
        expect_val(0, 32'h0041, "R3 init only");
        do_evt(7'h01);
        expect_val(0, 32'h01C0, "R12 init cleared by done");
        expect_val(1, 32'h1, "R7 irq on init done");
        do_wr(16'h0144);
        expect_val(0, 32'h0044, "R4 stop and clear");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule